// File: doc/BRIEF.md
# CCD Sensor Timing Pulse Generator

This block produces the line and frame timing that a CCD sensor front end and the camera processor behind it run on. A free-running pixel counter and line counter form the time base. From them the block decodes a horizontal definition pulse (HD) at the start of every line and a vertical definition pulse (VD) on the first line of every frame. It also decodes two programmable clamp windows (optical black and dummy), a charge-reset shutter line, and qualifiers that mark the active pixels, the active lines and the lines that carry real sensor readout.

Two geometries are supported: a PAL medium-resolution mode and a VGA progressive mode. After the last real sensor line, HD keeps pulsing until the frame reaches a standard line total. Eight frame-rate settings each stretch vertical blanking by a whole number of extra lines. A byte-wide write port loads a shadow register set. The shadow set is copied into the working set only at a frame boundary, so no pulse ever changes shape in the middle of a frame.

Top module: `ccd_timing_gen`

## Requirements
- R1: While reset is held and on the first clock after it, both counters are zero and every setting is zero (PAL mode, rate 0, shutter line 0, all clamp positions 0). So HD, VD, shutter, pixActive, lineActive and sensorLine are high, and both clamp outputs are low.
- R2: Each line lasts 685 pixel clocks in PAL mode and 823 in VGA mode (parameters). HD is high for the first 16 pixel clocks of every line.
- R3: A frame lasts 312 lines in PAL mode and 525 in VGA mode, plus the rate setting (0 to 7) in extra lines. VD is high for the whole of line 0.
- R4: HD keeps running on every line of the frame, including the lines after the real sensor lines. sensorLine is high only on lines below 292 (PAL) or 486 (VGA).
- R5: pixActive is high while the pixel count is below 512 (PAL) or 640 (VGA). lineActive is high while the line count is below 288 (PAL) or 480 (VGA).
- R6: On every line, obClamp is high when the pixel count is at least the optical-black start and below its stop. dmClamp does the same with the dummy start and stop. A start at or above the stop gives no window.
- R7: Each clamp position is 10 bits wide: a low byte from its own register plus two upper bits from the shared register at address 7. The upper bits sit at [1:0] for optical-black start, [3:2] for optical-black stop, [5:4] for dummy start and [7:6] for dummy stop.
- R8: The shutter output is high for the whole line whose number equals the 10-bit shutter value. Address 1 holds the low byte and bits [1:0] at address 2 hold the upper bits. A value above the last active line is clamped to the last active line.
- R9: Address 0 selects the mode with bit 0 (0 = PAL, 1 = VGA) and the rate setting with bits [3:1]. Addresses 3, 4, 5 and 6 hold the low bytes of optical-black start, optical-black stop, dummy start and dummy stop.
- R10: A write changes only the shadow set. The shadow set is copied into the working set on the clock that ends a frame. A write made on that same last clock of a frame takes effect only one frame later.
- R11: Writes to addresses 8 to 15 change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 8 | Register write data |
| hd | output | 1 | Horizontal definition pulse |
| vd | output | 1 | Vertical definition pulse |
| obClamp | output | 1 | Optical-black clamp window |
| dmClamp | output | 1 | Dummy clamp window |
| shutter | output | 1 | Charge-reset shutter line |
| pixActive | output | 1 | Pixel lies in the active width |
| lineActive | output | 1 | Line lies in the active height |
| sensorLine | output | 1 | Line carries real sensor readout |

## Verification
The case that needs the most care is a register write that lands on the very clock where the frame wraps and the working settings are reloaded. The bench steps its reference model until it stands on the last pixel of the last line. It then issues a mode and rate write on exactly that clock and expects the old geometry for one more full frame. After that, the bench expects the new geometry. Every cycle around this point, the scoreboard compares all eight outputs against the model, so an early or a lost update shows up as a line-length or VD mismatch.

// File: rtl/ccd_timing_pkg.sv
package ccd_timing_pkg;
  localparam int POS_W  = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int HI_W   = POS_W - DATA_W;

  typedef struct packed {
    logic              modeVga;
    logic [2:0]        rateSel;
    logic [POS_W-1:0]  shutterLine;
    logic [POS_W-1:0]  obStart;
    logic [POS_W-1:0]  obStop;
    logic [POS_W-1:0]  dmStart;
    logic [POS_W-1:0]  dmStop;
  } timingCfg_t;

  typedef struct packed {
    logic lineWrap;
    logic frameWrap;
  } tbStrobe_t;

  localparam timingCfg_t CFG_RESET = '0;

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SHUT_L = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SHUT_H = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_OBS_L  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_OBE_L  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DMS_L  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_DME_L  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_CLP_H  = ADDR_W'(7);
endpackage

// File: rtl/ccd_timing_ctrl.sv
module ccd_timing_ctrl
  import ccd_timing_pkg::*;
#(
  parameter int PAL_PIX_TOTAL  = 685,
  parameter int VGA_PIX_TOTAL  = 823,
  parameter int PAL_LINE_FRAME = 312,
  parameter int VGA_LINE_FRAME = 525
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [POS_W-1:0]  pixCnt,
  output logic [POS_W-1:0]  lineCnt,
  output timingCfg_t        cfgWork,
  output tbStrobe_t         strobe
);
  localparam logic [POS_W-1:0] PAL_PIX_LAST = POS_W'(PAL_PIX_TOTAL - 1);
  localparam logic [POS_W-1:0] VGA_PIX_LAST = POS_W'(VGA_PIX_TOTAL - 1);
  localparam logic [POS_W-1:0] PAL_FRM_LAST = POS_W'(PAL_LINE_FRAME - 1);
  localparam logic [POS_W-1:0] VGA_FRM_LAST = POS_W'(VGA_LINE_FRAME - 1);

  timingCfg_t       cfgShadow;
  logic [POS_W-1:0] pixLast;
  logic [POS_W-1:0] lineLast;

  // Line length follows the mode; frame length adds the rate stretch.
  always_comb begin
    pixLast  = cfgWork.modeVga ? VGA_PIX_LAST : PAL_PIX_LAST;
    lineLast = (cfgWork.modeVga ? VGA_FRM_LAST : PAL_FRM_LAST)
             + POS_W'(cfgWork.rateSel);
    strobe.lineWrap  = (pixCnt == pixLast);
    strobe.frameWrap = strobe.lineWrap && (lineCnt == lineLast);
  end

  // Shadow register bank, written from the byte port.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgShadow <= CFG_RESET;
    end else if (wrEn) begin
      case (wrAddr)
        A_CTRL: begin
          cfgShadow.modeVga <= wrData[0];
          cfgShadow.rateSel <= wrData[3:1];
        end
        A_SHUT_L: cfgShadow.shutterLine[DATA_W-1:0]     <= wrData;
        A_SHUT_H: cfgShadow.shutterLine[POS_W-1:DATA_W] <= wrData[HI_W-1:0];
        A_OBS_L:  cfgShadow.obStart[DATA_W-1:0]         <= wrData;
        A_OBE_L:  cfgShadow.obStop[DATA_W-1:0]          <= wrData;
        A_DMS_L:  cfgShadow.dmStart[DATA_W-1:0]         <= wrData;
        A_DME_L:  cfgShadow.dmStop[DATA_W-1:0]          <= wrData;
        A_CLP_H: begin
          cfgShadow.obStart[POS_W-1:DATA_W] <= wrData[HI_W-1:0];
          cfgShadow.obStop[POS_W-1:DATA_W]  <= wrData[2*HI_W-1:HI_W];
          cfgShadow.dmStart[POS_W-1:DATA_W] <= wrData[3*HI_W-1:2*HI_W];
          cfgShadow.dmStop[POS_W-1:DATA_W]  <= wrData[4*HI_W-1:3*HI_W];
        end
        default: ;
      endcase
    end
  end

  // Time base plus the frame-boundary copy into the working set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineCnt <= '0;
      cfgWork <= CFG_RESET;
    end else if (strobe.lineWrap) begin
      pixCnt <= '0;
      if (strobe.frameWrap) begin
        lineCnt <= '0;
        cfgWork <= cfgShadow;
      end else begin
        lineCnt <= lineCnt + POS_W'(1);
      end
    end else begin
      pixCnt <= pixCnt + POS_W'(1);
    end
  end

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.frameWrap |=> $stable(cfgWork));

  p_line_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    lineCnt <= lineLast);

  p_pix_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lineWrap |=> (pixCnt == '0));
endmodule

// File: rtl/ccd_timing_dp.sv
module ccd_timing_dp
  import ccd_timing_pkg::*;
#(
  parameter int HD_LEN          = 16,
  parameter int PAL_PIX_ACT     = 512,
  parameter int VGA_PIX_ACT     = 640,
  parameter int PAL_LINE_ACT    = 288,
  parameter int VGA_LINE_ACT    = 480,
  parameter int PAL_LINE_SENSOR = 292,
  parameter int VGA_LINE_SENSOR = 486
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [POS_W-1:0] pixCnt,
  input  logic [POS_W-1:0] lineCnt,
  input  tbStrobe_t        strobe,
  input  logic             modeVga,
  input  logic [POS_W-1:0] shutterLine,
  input  logic [POS_W-1:0] obStart,
  input  logic [POS_W-1:0] obStop,
  input  logic [POS_W-1:0] dmStart,
  input  logic [POS_W-1:0] dmStop,
  output logic             hd,
  output logic             vd,
  output logic             obClamp,
  output logic             dmClamp,
  output logic             shutter,
  output logic             pixActive,
  output logic             lineActive,
  output logic             sensorLine
);
  localparam logic [POS_W-1:0] HD_END      = POS_W'(HD_LEN);
  localparam logic [POS_W-1:0] PAL_PIX_END = POS_W'(PAL_PIX_ACT);
  localparam logic [POS_W-1:0] VGA_PIX_END = POS_W'(VGA_PIX_ACT);
  localparam logic [POS_W-1:0] PAL_ACT_END = POS_W'(PAL_LINE_ACT);
  localparam logic [POS_W-1:0] VGA_ACT_END = POS_W'(VGA_LINE_ACT);
  localparam logic [POS_W-1:0] PAL_SEN_END = POS_W'(PAL_LINE_SENSOR);
  localparam logic [POS_W-1:0] VGA_SEN_END = POS_W'(VGA_LINE_SENSOR);

  logic [POS_W-1:0] actLineEnd;
  logic [POS_W-1:0] actLineLast;
  logic [POS_W-1:0] shutAt;

  always_comb begin
    actLineEnd  = modeVga ? VGA_ACT_END : PAL_ACT_END;
    actLineLast = actLineEnd - POS_W'(1);
    shutAt      = (shutterLine > actLineLast) ? actLineLast : shutterLine;

    hd         = (pixCnt < HD_END);
    vd         = (lineCnt == '0);
    pixActive  = (pixCnt < (modeVga ? VGA_PIX_END : PAL_PIX_END));
    lineActive = (lineCnt < actLineEnd);
    sensorLine = (lineCnt < (modeVga ? VGA_SEN_END : PAL_SEN_END));
    obClamp    = (pixCnt >= obStart) && (pixCnt < obStop);
    dmClamp    = (pixCnt >= dmStart) && (pixCnt < dmStop);
    shutter    = (lineCnt == shutAt);
  end

  p_wrap_hd_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lineWrap |=> hd);

  p_hd_in_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    hd |-> pixActive);

  p_frame_vd_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameWrap |=> vd);

  p_vd_one_line_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vd) |-> $rose(pixActive));

  p_active_in_sensor_r4: assert property (@(posedge clk) disable iff (!rstN)
    lineActive |-> sensorLine);

  p_shutter_active_r8: assert property (@(posedge clk) disable iff (!rstN)
    shutter |-> lineActive);
endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccd_timing_pkg::*;
#(
  parameter int HD_LEN          = 16,
  parameter int PAL_PIX_TOTAL   = 685,
  parameter int VGA_PIX_TOTAL   = 823,
  parameter int PAL_PIX_ACT     = 512,
  parameter int VGA_PIX_ACT     = 640,
  parameter int PAL_LINE_ACT    = 288,
  parameter int VGA_LINE_ACT    = 480,
  parameter int PAL_LINE_SENSOR = 292,
  parameter int VGA_LINE_SENSOR = 486,
  parameter int PAL_LINE_FRAME  = 312,
  parameter int VGA_LINE_FRAME  = 525
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              hd,
  output logic              vd,
  output logic              obClamp,
  output logic              dmClamp,
  output logic              shutter,
  output logic              pixActive,
  output logic              lineActive,
  output logic              sensorLine
);
  logic [POS_W-1:0] pixCnt;
  logic [POS_W-1:0] lineCnt;
  timingCfg_t       cfgWork;
  tbStrobe_t        strobe;

  ccd_timing_ctrl #(
    .PAL_PIX_TOTAL (PAL_PIX_TOTAL),
    .VGA_PIX_TOTAL (VGA_PIX_TOTAL),
    .PAL_LINE_FRAME(PAL_LINE_FRAME),
    .VGA_LINE_FRAME(VGA_LINE_FRAME)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .pixCnt (pixCnt),
    .lineCnt(lineCnt),
    .cfgWork(cfgWork),
    .strobe (strobe)
  );

  ccd_timing_dp #(
    .HD_LEN         (HD_LEN),
    .PAL_PIX_ACT    (PAL_PIX_ACT),
    .VGA_PIX_ACT    (VGA_PIX_ACT),
    .PAL_LINE_ACT   (PAL_LINE_ACT),
    .VGA_LINE_ACT   (VGA_LINE_ACT),
    .PAL_LINE_SENSOR(PAL_LINE_SENSOR),
    .VGA_LINE_SENSOR(VGA_LINE_SENSOR)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pixCnt     (pixCnt),
    .lineCnt    (lineCnt),
    .strobe     (strobe),
    .modeVga    (cfgWork.modeVga),
    .shutterLine(cfgWork.shutterLine),
    .obStart    (cfgWork.obStart),
    .obStop     (cfgWork.obStop),
    .dmStart    (cfgWork.dmStart),
    .dmStop     (cfgWork.dmStop),
    .hd         (hd),
    .vd         (vd),
    .obClamp    (obClamp),
    .dmClamp    (dmClamp),
    .shutter    (shutter),
    .pixActive  (pixActive),
    .lineActive (lineActive),
    .sensorLine (sensorLine)
  );
endmodule

// File: tb/sim_ccd_timing_gen.sv
module sim_ccd_timing_gen;
  localparam int HDL  = 4;
  localparam int PPT  = 40, VPT = 50;
  localparam int PPA  = 30, VPA = 40;
  localparam int PLA  = 12, VLA = 20;
  localparam int PLS  = 14, VLS = 22;
  localparam int PLF  = 18, VLF = 26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic hd, vd, obClamp, dmClamp, shutter, pixActive, lineActive, sensorLine;

  always #5 clk = ~clk;

  ccd_timing_gen #(
    .HD_LEN(HDL), .PAL_PIX_TOTAL(PPT), .VGA_PIX_TOTAL(VPT),
    .PAL_PIX_ACT(PPA), .VGA_PIX_ACT(VPA), .PAL_LINE_ACT(PLA), .VGA_LINE_ACT(VLA),
    .PAL_LINE_SENSOR(PLS), .VGA_LINE_SENSOR(VLS),
    .PAL_LINE_FRAME(PLF), .VGA_LINE_FRAME(VLF)
  ) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hd(hd), .vd(vd), .obClamp(obClamp), .dmClamp(dmClamp), .shutter(shutter),
    .pixActive(pixActive), .lineActive(lineActive), .sensorLine(sensorLine)
  );

  typedef struct {
    int mode; int rate; int shut; int obS; int obE; int dmS; int dmE;
  } mcfg_t;

  mcfg_t mShadow, mWork;
  int mPix = 0, mLine = 0;
  int checks = 0, failures = 0;
  bit done = 0;
  string phase = "R1";
  logic [7:0] expQ[$];

  function automatic string tagOf(int b);
    case (b)
      7: return "R2 hd";
      6: return "R3 vd";
      5: return "R6 obClamp";
      4: return "R6 dmClamp";
      3: return "R8 shutter";
      2: return "R5 pixActive";
      1: return "R5 lineActive";
      default: return "R4 sensorLine";
    endcase
  endfunction

  function automatic logic [7:0] model();
    int pa, la, ls, sl;
    logic [7:0] e;
    pa = mWork.mode ? VPA : PPA;
    la = mWork.mode ? VLA : PLA;
    ls = mWork.mode ? VLS : PLS;
    sl = (mWork.shut > la - 1) ? la - 1 : mWork.shut;
    e[7] = mPix < HDL;
    e[6] = mLine == 0;
    e[5] = (mPix >= mWork.obS) && (mPix < mWork.obE);
    e[4] = (mPix >= mWork.dmS) && (mPix < mWork.dmE);
    e[3] = mLine == sl;
    e[2] = mPix < pa;
    e[1] = mLine < la;
    e[0] = mLine < ls;
    return e;
  endfunction

  task automatic predict();
    expQ.push_back(model());
  endtask

  task automatic monitor();
    logic [7:0] got, exp;
    exp = expQ.pop_front();
    got = {hd, vd, obClamp, dmClamp, shutter, pixActive, lineActive, sensorLine};
    checks++;
    if (got !== exp) begin
      failures++;
      for (int b = 7; b >= 0; b--)
        if (got[b] !== exp[b]) begin
          $display("FAIL %s [%s] pix=%0d line=%0d actual=%b expected=%b",
                   tagOf(b), phase, mPix, mLine, got[b], exp[b]);
          break;
        end
    end
  endtask

  task automatic applyWrite(int a, int d);
    case (a)
      0: begin mShadow.mode = d & 1; mShadow.rate = (d >> 1) & 7; end
      1: mShadow.shut = (mShadow.shut & 'h300) | d;
      2: mShadow.shut = (mShadow.shut & 'hFF) | ((d & 3) << 8);
      3: mShadow.obS = (mShadow.obS & 'h300) | d;
      4: mShadow.obE = (mShadow.obE & 'h300) | d;
      5: mShadow.dmS = (mShadow.dmS & 'h300) | d;
      6: mShadow.dmE = (mShadow.dmE & 'h300) | d;
      7: begin
        mShadow.obS = (mShadow.obS & 'hFF) | ((d & 3) << 8);
        mShadow.obE = (mShadow.obE & 'hFF) | (((d >> 2) & 3) << 8);
        mShadow.dmS = (mShadow.dmS & 'hFF) | (((d >> 4) & 3) << 8);
        mShadow.dmE = (mShadow.dmE & 'hFF) | (((d >> 6) & 3) << 8);
      end
      default: ;
    endcase
  endtask

  function automatic bit atFrameEnd();
    int pt, lf;
    pt = mWork.mode ? VPT : PPT;
    lf = (mWork.mode ? VLF : PLF) + mWork.rate;
    return (mPix == pt - 1) && (mLine == lf - 1);
  endfunction

  // Called at a falling edge with the inputs for the next rising edge set.
  task automatic cycle();
    int pt, lf;
    predict();
    monitor();
    pt = mWork.mode ? VPT : PPT;
    lf = (mWork.mode ? VLF : PLF) + mWork.rate;
    if (mPix == pt - 1) begin
      mPix = 0;
      if (mLine == lf - 1) begin
        mLine = 0;
        mWork = mShadow;
      end else mLine++;
    end else mPix++;
    if (wrEn) applyWrite(int'(wrAddr), int'(wrData));
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic writeReg(int a, int d);
    wrEn = 1'b1; wrAddr = 4'(a); wrData = 8'(d);
    cycle();
    wrEn = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    mShadow = '{0, 0, 0, 0, 0, 0, 0};
    mWork   = mShadow;
    repeat (3) @(negedge clk);
    // R1: reset state observed while reset is held
    checks++;
    if ({hd, vd, obClamp, dmClamp, shutter, pixActive, lineActive, sensorLine} !== 8'b1100_1111) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%b expected=%b",
               {hd, vd, obClamp, dmClamp, shutter, pixActive, lineActive, sensorLine}, 8'b1100_1111);
    end
    rstN = 1'b1;
    phase = "R1 R2 R3 R4 R5 defaults";
    run(2 * PPT * PLF);

    phase = "R6 R8 R9 program";
    writeReg(3, 5);  writeReg(4, 12);
    writeReg(5, 20); writeReg(6, 25);
    writeReg(1, 3);  writeReg(0, 'h04);
    run(3 * PPT * (PLF + 2));

    phase = "R8 shutter clamp, R6 empty window";
    writeReg(1, 100); writeReg(3, 12); writeReg(4, 5);
    run(2 * PPT * (PLF + 2) + 10);

    phase = "R7 upper bits";
    writeReg(3, 5); writeReg(4, 12);
    writeReg(7, 'h10);
    writeReg(1, 2); writeReg(2, 1);
    run(2 * PPT * (PLF + 2) + 10);
    writeReg(7, 'h00); writeReg(1, 7); writeReg(2, 0);

    phase = "R9 VGA rate 7";
    writeReg(0, 'h0F);
    run(PPT * (PLF + 2) + 2 * VPT * (VLF + 7));

    phase = "R10 write on last clock";
    while (!atFrameEnd()) cycle();
    writeReg(0, 'h02);
    run(VPT * (VLF + 7) + 2 * PPT * (PLF + 1));

    phase = "R11 unmapped writes";
    writeReg(9, 'hFF); writeReg(15, 'hFF); writeReg(8, 'h0F);
    run(2 * PPT * (PLF + 1) + 5);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired in phase %s", phase);
      summary();
      $finish;
    end
  end
endmodule